// File: doc/BRIEF.md
# Dual-CAS DRAM Device Emulator

This block is a synthesizable stand-in for an asynchronous x16 DRAM with two column strobes, one per byte. It is placed opposite a DRAM controller so that the controller can be exercised against a target that checks itself. A fast system clock samples the row strobe, both column strobes, write enable, output enable, the multiplexed address and the write data. From the order of the edges it decides what kind of cycle is in progress. It keeps the data in a small parameterized array and returns read data together with an output-enable flag.

The two column strobes act together as one strobe. That strobe becomes active when the first of the two falls and inactive when the last of the two rises. The block supports early write, late write, fast page access, refresh by row address only, refresh with CAS before RAS using an internal row counter, and hidden refresh. It keeps a per-row refreshed map and reports when every row has been covered.

The device becomes usable only after a run of wake-up RAS cycles. An access attempted before that raises a sticky error flag. Nanosecond timing and charge loss are not modelled; only the order of the sampled edges matters.

Top module: `dual_cas_dram_model`

## Requirements
- R1: After reset, dq_oe, ready, proto_err and rows_done are all 0.
- R2: ready rises after the WAKE_CYCLES-th (default 8) sampled falling edge of ras_n since reset, counting every kind of RAS cycle, and then stays 1 until reset.
- R3: A combined CAS falling edge inside a row cycle (RAS fell while both CAS were high) before ready is 1 sets proto_err, which stays 1 until reset. Such an access writes nothing and never turns the outputs on.
- R4: The combined CAS becomes active when the first of casl_n/cash_n falls. The column is latched and the read word is fetched at that edge. Read data stays driven while at least one of the two lines is still low.
- R5: In a write, only byte lanes whose own CAS went low are updated: casl_n controls dq bits 7:0 and cash_n controls dq bits 15:8. The other lane keeps its old contents.
- R6: If we_n is low when the combined CAS falls, the cycle is an early write, and dq_oe stays 0 for that whole CAS pulse, even with oe_n low.
- R7: A falling we_n while the combined CAS is already low in a row cycle (late write) writes dq_in into the lanes whose CAS is low. With oe_n high, dq_oe stays 0 throughout.
- R8: dq_oe is 1 only while a read word is valid, oe_n is low and at least one CAS line is low. The valid word is dropped when oe_n rises (dq_oe stays 0 even if oe_n falls again, until the next CAS fall), or when ras_n and both CAS lines are high.
- R9: In fast page mode, each new combined CAS falling edge while ras_n stays low uses a new column in the same row, for both reads and writes.
- R10: If either CAS line is low when ras_n falls, the cycle is a CAS-before-RAS refresh. The row given by an internal counter (0 after reset, wrapping) is marked refreshed and the counter advances. No write takes place, and no new read data is driven.
- R11: Hidden refresh: after a read, if CAS is held low while ras_n rises and falls again, dq_oe stays 1 with the same data throughout.
- R12: A falling ras_n with both CAS lines high marks the row on addr as refreshed. rows_done becomes 1 once every row has been marked by such a cycle or by R10, and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Column strobe for the low byte, active low |
| cash_n | input | 1 | Column strobe for the high byte, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 16 | Write data from the controller |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | High while the device drives dq_out |
| ready | output | 1 | Wake-up sequence complete |
| proto_err | output | 1 | Sticky flag: access attempted before ready |
| rows_done | output | 1 | Every row has been refreshed since reset |

## Verification
A wrong phase or a latched column that is off shows up as the wrong word on dq_out, or as dq_oe in the wrong state. That is visible two clocks after the strobe edge that should have caused it, because one clock goes to sampling the pins and one to registering the state. A lane enable that is wrong only shows up in a later read of the same location, so each write test ends with a read-back. A refresh counter or row map that drifts appears as rows_done rising one cycle too early or too late at the end of a complete sweep, so the sweep stops one row short and checks for 0 before it finishes.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;

    typedef struct packed {
        logic ras;
        logic casl;
        logic cash;
        logic we;
        logic oe;
    } strobe_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROW  = 2'd1,
        PH_CBR  = 2'd2
    } phase_e;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;

endpackage

// File: rtl/dram_pin_sampler.sv
module dram_pin_sampler
    import dram_emu_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DQ_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           pins_raw,
    input  logic [ADDR_W-1:0] addr_raw,
    input  logic [DQ_W-1:0]   dq_raw,
    output strobe_t           cur,
    output strobe_t           prev,
    output logic [ADDR_W-1:0] addr_s,
    output logic [DQ_W-1:0]   dq_s
);

    typedef struct packed {
        strobe_t           now;
        strobe_t           old;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   dq;
    } smp_t;

    localparam strobe_t IDLE_PINS = '{ras: 1'b1, casl: 1'b1, cash: 1'b1, we: 1'b1, oe: 1'b1};

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.now  = pins_raw;
        smp_d.old  = smp_q.now;
        smp_d.addr = addr_raw;
        smp_d.dq   = dq_raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q.now  <= IDLE_PINS;
            smp_q.old  <= IDLE_PINS;
            smp_q.addr <= '0;
            smp_q.dq   <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign cur    = smp_q.now;
    assign prev   = smp_q.old;
    assign addr_s = smp_q.addr;
    assign dq_s   = smp_q.dq;

endmodule

// File: rtl/dram_refresh_track.sv
module dram_refresh_track #(
    parameter int ROW_BITS    = 4,
    parameter int WAKE_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_fall,
    input  logic                cbr_go,
    input  logic                ror_go,
    input  logic [ROW_BITS-1:0] ror_row,
    output logic                ready,
    output logic                rows_done
);

    localparam int ROWS   = 1 << ROW_BITS;
    localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [WAKE_W-1:0] WAKE_LIM = WAKE_W'(WAKE_CYCLES);

    typedef struct packed {
        logic [WAKE_W-1:0]   wake;
        logic [ROW_BITS-1:0] ref_cnt;
        logic [ROWS-1:0]     map;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (ras_fall && (trk_q.wake != WAKE_LIM)) begin
            trk_d.wake = trk_q.wake + 1'b1;
        end
        if (ror_go) begin
            trk_d.map[ror_row] = 1'b1;
        end
        if (cbr_go) begin
            trk_d.map[trk_q.ref_cnt] = 1'b1;
            trk_d.ref_cnt            = trk_q.ref_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign ready     = (trk_q.wake == WAKE_LIM);
    assign rows_done = &trk_q.map;

endmodule

// File: rtl/dram_store.sv
module dram_store #(
    parameter int AW     = 8,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        lane_wr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_wr[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/dual_cas_dram_model.sv
module dual_cas_dram_model
    import dram_emu_pkg::*;
#(
    parameter int ROW_BITS    = 4,
    parameter int COL_BITS    = 4,
    parameter int WAKE_CYCLES = 8,
    parameter int ADDR_W      = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              casl_n,
    input  logic              cash_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic              dq_oe,
    output logic              ready,
    output logic              proto_err,
    output logic              rows_done
);

    localparam int DQ_W = LANE_W * LANES;
    localparam int AW   = ROW_BITS + COL_BITS;

    typedef struct packed {
        phase_e              phase;
        logic [ROW_BITS-1:0] row;
        logic [COL_BITS-1:0] col;
        logic [DQ_W-1:0]     rd;
        logic                valid;
        logic                err;
    } core_t;

    strobe_t             s_cur, s_prev;
    logic [ADDR_W-1:0]   s_addr;
    logic [DQ_W-1:0]     s_dq;
    logic [DQ_W-1:0]     mem_rdata;
    logic [AW-1:0]       mem_addr;
    logic [LANES-1:0]    lane_wr;
    logic [LANES-1:0]    cas_low, cas_low_p, lane_fall;
    logic                cas_any, cas_any_p, cas_fall;
    logic                ras_fall, ras_rise, we_fall, oe_rise;
    logic                cbr_go, ror_go;
    logic [COL_BITS-1:0] col_eff;
    core_t               core_d, core_q;

    dram_pin_sampler #(
        .ADDR_W (ADDR_W),
        .DQ_W   (DQ_W)
    ) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_raw ('{ras: ras_n, casl: casl_n, cash: cash_n, we: we_n, oe: oe_n}),
        .addr_raw (addr),
        .dq_raw   (dq_in),
        .cur      (s_cur),
        .prev     (s_prev),
        .addr_s   (s_addr),
        .dq_s     (s_dq)
    );

    dram_refresh_track #(
        .ROW_BITS    (ROW_BITS),
        .WAKE_CYCLES (WAKE_CYCLES)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_fall  (ras_fall),
        .cbr_go    (cbr_go),
        .ror_go    (ror_go),
        .ror_row   (s_addr[ROW_BITS-1:0]),
        .ready     (ready),
        .rows_done (rows_done)
    );

    dram_store #(
        .AW     (AW),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_store (
        .clk     (clk),
        .addr    (mem_addr),
        .lane_wr (lane_wr),
        .wdata   (s_dq),
        .rdata   (mem_rdata)
    );

    // Edge detection on the sampled strobes
    always_comb begin
        cas_low   = {~s_cur.cash,  ~s_cur.casl};
        cas_low_p = {~s_prev.cash, ~s_prev.casl};
        lane_fall = cas_low & ~cas_low_p;
        cas_any   = |cas_low;
        cas_any_p = |cas_low_p;
        cas_fall  = cas_any & ~cas_any_p;
        ras_fall  = s_prev.ras & ~s_cur.ras;
        ras_rise  = ~s_prev.ras & s_cur.ras;
        we_fall   = s_prev.we & ~s_cur.we;
        oe_rise   = ~s_prev.oe & s_cur.oe;
        col_eff   = cas_fall ? s_addr[COL_BITS-1:0] : core_q.col;
        mem_addr  = {core_q.row, col_eff};
    end

    // Cycle decode and next state
    always_comb begin
        core_d  = core_q;
        lane_wr = '0;
        cbr_go  = 1'b0;
        ror_go  = 1'b0;

        if (ras_fall) begin
            if (cas_any) begin
                core_d.phase = PH_CBR;
                cbr_go       = 1'b1;
            end else begin
                core_d.phase = PH_ROW;
                core_d.row   = s_addr[ROW_BITS-1:0];
                ror_go       = 1'b1;
            end
        end else if (ras_rise) begin
            core_d.phase = PH_IDLE;
        end else if (core_q.phase == PH_ROW) begin
            if (cas_fall) begin
                core_d.col = s_addr[COL_BITS-1:0];
            end
            if (cas_fall && !ready) begin
                core_d.err = 1'b1;
            end
            if (ready) begin
                lane_wr = (lane_fall & {LANES{~s_cur.we}})
                        | ({LANES{we_fall}} & cas_low & ~lane_fall);
                if (cas_fall) begin
                    if (s_cur.we) begin
                        core_d.rd    = mem_rdata;
                        core_d.valid = 1'b1;
                    end else begin
                        core_d.valid = 1'b0;
                    end
                end
            end
        end

        if (oe_rise) begin
            core_d.valid = 1'b0;
        end
        if (s_cur.ras && !cas_any) begin
            core_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q.phase <= PH_IDLE;
            core_q.row   <= '0;
            core_q.col   <= '0;
            core_q.rd    <= '0;
            core_q.valid <= 1'b0;
            core_q.err   <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    assign dq_out    = core_q.rd;
    assign dq_oe     = core_q.valid & ~s_cur.oe & cas_any;
    assign proto_err = core_q.err;

endmodule

// File: rtl/dual_cas_dram_model_chk.sv
module dual_cas_dram_model_chk (
    input logic clk,
    input logic rst_n,
    input logic casl_n,
    input logic cash_n,
    input logic oe_n,
    input logic dq_oe,
    input logic ready,
    input logic proto_err,
    input logic rows_done
);

    // R8: driving needs OE low and a CAS line low at the previous sample
    a_r8_drive_needs_oe_cas: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!$past(oe_n) && (!$past(casl_n) || !$past(cash_n))));

    // R3: nothing is driven before wake-up is complete
    a_r3_quiet_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !dq_oe);

    // R2: ready never drops
    a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R3: error flag is sticky
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R12: coverage flag is sticky
    a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rows_done |=> rows_done);

endmodule

bind dual_cas_dram_model dual_cas_dram_model_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .casl_n    (casl_n),
    .cash_n    (cash_n),
    .oe_n      (oe_n),
    .dq_oe     (dq_oe),
    .ready     (ready),
    .proto_err (proto_err),
    .rows_done (rows_done)
);

// File: tb/dual_cas_dram_model_bench.sv
module dual_cas_dram_model_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, casl_n = 1'b1, cash_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe, ready, proto_err, rows_done;
    int          n_chk = 0;
    int          n_err = 0;

    always #2 clk = ~clk;

    dual_cas_dram_model u_dual_cas_dram_model (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_n     (ras_n),
        .casl_n    (casl_n),
        .cash_n    (cash_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .dq_in     (dq_in),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .ready     (ready),
        .proto_err (proto_err),
        .rows_done (rows_done)
    );

    task automatic step();
        repeat (3) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic close_row();
        casl_n = 1'b1; cash_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; step();
        ras_n = 1'b1; step();
    endtask

    task automatic open_row(input logic [3:0] row);
        addr = row; step();
        ras_n = 1'b0; step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step();
        rst_n = 1'b1; step();
    endtask

    task automatic ror(input logic [3:0] row);
        open_row(row);
        ras_n = 1'b1; step();
    endtask

    task automatic cbr();
        casl_n = 1'b0; cash_n = 1'b0; step();
        ras_n = 1'b0; dq_in = 16'h0BAD; we_n = 1'b0; step();
        chk("R10 cbr outputs off", {15'd0, dq_oe}, 16'd0);
        ras_n = 1'b1; we_n = 1'b1; step();
        casl_n = 1'b1; cash_n = 1'b1; step();
    endtask

    task automatic wr_word(input logic [3:0] row, input logic [3:0] col,
                           input logic [15:0] data, input logic [1:0] lanes);
        open_row(row);
        addr = col; we_n = 1'b0; oe_n = 1'b0; dq_in = data; step();
        casl_n = ~lanes[0]; cash_n = ~lanes[1]; step();
        chk("R6 early write outputs off", {15'd0, dq_oe}, 16'd0);
        close_row();
    endtask

    task automatic rd_word(input logic [3:0] row, input logic [3:0] col,
                           input logic [15:0] exp, input string req);
        open_row(row);
        addr = col; oe_n = 1'b0; step();
        casl_n = 1'b0; cash_n = 1'b0; step();
        chk(req, {15'd0, dq_oe}, 16'd1);
        chk(req, dq_out, exp);
        close_row();
    endtask

    task automatic t_reset_state();
        chk("R1 dq_oe", {15'd0, dq_oe}, 16'd0);
        chk("R1 ready", {15'd0, ready}, 16'd0);
        chk("R1 proto_err", {15'd0, proto_err}, 16'd0);
        chk("R1 rows_done", {15'd0, rows_done}, 16'd0);
    endtask

    task automatic t_wake_and_ror_sweep();
        for (int r = 0; r < 7; r++) ror(4'(r));
        chk("R2 not ready after 7", {15'd0, ready}, 16'd0);
        ror(4'd7);
        chk("R2 ready after 8", {15'd0, ready}, 16'd1);
        for (int r = 8; r < 15; r++) ror(4'(r));
        chk("R12 one row missing", {15'd0, rows_done}, 16'd0);
        ror(4'd15);
        chk("R12 all rows covered", {15'd0, rows_done}, 16'd1);
    endtask

    task automatic t_word_and_lanes();
        wr_word(4'd2, 4'd3, 16'h1234, 2'b11);
        rd_word(4'd2, 4'd3, 16'h1234, "R4 full word read");
        wr_word(4'd2, 4'd3, 16'hFFAB, 2'b01);
        rd_word(4'd2, 4'd3, 16'h12AB, "R5 low lane only");
        wr_word(4'd2, 4'd3, 16'hCDFF, 2'b10);
        rd_word(4'd2, 4'd3, 16'hCDAB, "R5 high lane only");
    endtask

    task automatic t_late_write();
        open_row(4'd5);
        addr = 4'd7; step();
        casl_n = 1'b0; cash_n = 1'b0; step();
        chk("R7 oe high keeps off", {15'd0, dq_oe}, 16'd0);
        dq_in = 16'hBEEF; we_n = 1'b0; step();
        chk("R7 off during late write", {15'd0, dq_oe}, 16'd0);
        close_row();
        rd_word(4'd5, 4'd7, 16'hBEEF, "R7 late write stored");
    endtask

    task automatic t_page();
        open_row(4'd5);
        addr = 4'd0; we_n = 1'b0; dq_in = 16'h1111; step();
        casl_n = 1'b0; cash_n = 1'b0; step();
        casl_n = 1'b1; cash_n = 1'b1; step();
        addr = 4'd1; dq_in = 16'h2222; step();
        casl_n = 1'b0; cash_n = 1'b0; step();
        close_row();
        open_row(4'd5);
        addr = 4'd0; oe_n = 1'b0; step();
        casl_n = 1'b0; cash_n = 1'b0; step();
        chk("R9 page col0", dq_out, 16'h1111);
        casl_n = 1'b1; cash_n = 1'b1; step();
        chk("R8 off between page strobes", {15'd0, dq_oe}, 16'd0);
        addr = 4'd1; step();
        casl_n = 1'b0; cash_n = 1'b0; step();
        chk("R9 page col1 on", {15'd0, dq_oe}, 16'd1);
        chk("R9 page col1", dq_out, 16'h2222);
        close_row();
    endtask

    task automatic t_oe_rule();
        open_row(4'd2);
        addr = 4'd3; step();
        casl_n = 1'b0; cash_n = 1'b0; step();
        chk("R8 oe high off", {15'd0, dq_oe}, 16'd0);
        oe_n = 1'b0; step();
        chk("R8 oe low on", {15'd0, dq_oe}, 16'd1);
        oe_n = 1'b1; step();
        oe_n = 1'b0; step();
        chk("R8 stays off after oe pulse", {15'd0, dq_oe}, 16'd0);
        close_row();
    endtask

    task automatic t_combined_cas();
        open_row(4'd2);
        addr = 4'd3; oe_n = 1'b0; step();
        casl_n = 1'b0; step();
        chk("R4 first cas starts", dq_out, 16'hCDAB);
        cash_n = 1'b0; step();
        casl_n = 1'b1; step();
        chk("R4 held by last cas", {15'd0, dq_oe}, 16'd1);
        cash_n = 1'b1; step();
        chk("R4 ends at last rise", {15'd0, dq_oe}, 16'd0);
        close_row();
    endtask

    task automatic t_hidden();
        open_row(4'd2);
        addr = 4'd3; oe_n = 1'b0; step();
        casl_n = 1'b0; cash_n = 1'b0; step();
        ras_n = 1'b1; step();
        chk("R11 driven through ras high", {15'd0, dq_oe}, 16'd1);
        ras_n = 1'b0; step();
        chk("R11 driven in refresh", {15'd0, dq_oe}, 16'd1);
        chk("R11 data held", dq_out, 16'hCDAB);
        casl_n = 1'b1; cash_n = 1'b1; step();
        chk("R8 off after cas rise", {15'd0, dq_oe}, 16'd0);
        close_row();
    endtask

    task automatic t_before_ready();
        do_reset();
        chk("R1 ready after reset", {15'd0, ready}, 16'd0);
        chk("R1 rows_done after reset", {15'd0, rows_done}, 16'd0);
        open_row(4'd2);
        addr = 4'd3; we_n = 1'b0; dq_in = 16'hA5A5; step();
        casl_n = 1'b0; cash_n = 1'b0; step();
        chk("R3 error raised", {15'd0, proto_err}, 16'd1);
        close_row();
        open_row(4'd2);
        addr = 4'd3; oe_n = 1'b0; step();
        casl_n = 1'b0; cash_n = 1'b0; step();
        chk("R3 no drive before ready", {15'd0, dq_oe}, 16'd0);
        close_row();
    endtask

    task automatic t_cbr_sweep();
        for (int i = 0; i < 5; i++) cbr();
        chk("R2 not ready after 7 falls", {15'd0, ready}, 16'd0);
        cbr();
        chk("R2 ready via refresh", {15'd0, ready}, 16'd1);
        for (int i = 6; i < 15; i++) cbr();
        chk("R10 counter one short", {15'd0, rows_done}, 16'd0);
        cbr();
        chk("R10 counter covered all", {15'd0, rows_done}, 16'd1);
        rd_word(4'd2, 4'd3, 16'hCDAB, "R3 early write ignored");
        rd_word(4'd5, 4'd7, 16'hBEEF, "R10 refresh wrote nothing");
        chk("R3 error still set", {15'd0, proto_err}, 16'd1);
    endtask

    initial begin
        step();
        rst_n = 1'b1; step();
        t_reset_state();
        t_wake_and_ror_sweep();
        t_word_and_lanes();
        t_late_write();
        t_page();
        t_oe_rule();
        t_combined_cas();
        t_hidden();
        t_before_ready();
        t_cbr_sweep();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule